// File: doc/BRIEF.md
# Serial Receiver Configuration and Status Port

This block is the host-facing register port of a serial avionics word receiver. A host talks to it as an SPI slave (mode 0, most significant bit first, chip select active low). Each frame starts with an 8-bit command byte. Depending on the command, data bytes follow from the host or a response is shifted back. The port can write and read back a 16-bit configuration word, read an 8-bit status byte built from the receive FIFO level flags, and load an 8-bit clock divisor.

The configuration word is decoded into plain control outputs for the receiver: line-rate choice, clock source, label filtering, parity checking, the bit-9/bit-10 match decoder, receiver enable, label bit order and the meaning of the flag pin. The block also produces the receiver's bit-rate strobe. A clock-enable runs either on every system clock or once per programmed divisor count. The strobe then fires once every 10 of those enables for the fast line rate, or once every 80 for the slow rate.

The SPI pins are sampled by the system clock through synchronizers, so the SPI clock must run well below the system clock (at least six system clocks per SPI half period). There is no streaming data path, so all pins are plain level signals without handshake.

Top module: `arx_cfg_port`

## Requirements
- R1: After reset every configuration output is 0, the stored divisor is 0, and `bit_tick` pulses once every 10 system clocks.
- R2: Command 0x10 followed by 16 data bits loads the configuration word, most significant bit first, on the last data bit. Outputs map as follows: `rate_low`=bit 0, `clk_src_div`=bit 1, `label_match_en`=bit 2, `parity_en`=bit 3, `decoder_en`=bit 4, `rx_enable`=bit 5, `decoder_match`={bit 8, bit 7}, `label_bit_rev`=bit 11, `flag_on_full`=bit 15. The other bits are stored only.
- R3: Command 0x0B returns the 16-bit configuration word on `spi_miso`, most significant bit first. The first bit is valid at the first SCK rising edge after the command byte.
- R4: Command 0x0A returns an 8-bit status byte: bit 0 = `fifo_empty`, bit 1 = `fifo_half`, bit 2 = `fifo_full`, bits 7..3 = 0.
- R5: Command 0x07 followed by 8 data bits loads the clock divisor.
- R6: The `bit_tick` period is 10 clock-enables when `rate_low`=0 and 80 when `rate_low`=1.
- R7: When `clk_src_div`=0 the clock-enable is active every system clock. When it is 1 the enable fires once every D system clocks, where D is the divisor, and a divisor of 0 acts as 1.
- R8: Any other command byte changes no state, and `spi_miso` stays 0 for the rest of that frame.
- R9: Raising `spi_cs_n` before the last data bit of a write frame leaves the configuration word and the divisor unchanged.
- R10: `rx_flag` follows `fifo_empty` when `flag_on_full`=0 and `fifo_full` when it is 1.
- R11: `spi_miso` is 0 while chip select is high and during the command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock from host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| fifo_empty | input | 1 | Receive FIFO holds no words |
| fifo_half | input | 1 | Receive FIFO at least half full |
| fifo_full | input | 1 | Receive FIFO full |
| rate_low | output | 1 | Slow line rate selected |
| clk_src_div | output | 1 | Divided clock source selected |
| label_match_en | output | 1 | Label recognition enabled |
| parity_en | output | 1 | Odd parity check enabled |
| decoder_en | output | 1 | Bit-9/bit-10 match decoder enabled |
| rx_enable | output | 1 | Receiver enabled |
| decoder_match | output | 2 | Required values of word bits 10 and 9 |
| label_bit_rev | output | 1 | Label bit order reversed |
| flag_on_full | output | 1 | Flag pin shows full instead of empty |
| rx_flag | output | 1 | Flag pin |
| bit_tick | output | 1 | One-clock line-rate strobe |

## Verification
The in-RTL assertions check on every cycle the properties that hold cycle by cycle. The configuration word never changes outside a completed write. Chip select high clears the frame state and silences MISO. An unknown command keeps MISO at 0. The line strobe is a single-cycle pulse, and the divided clock-enable never fires on adjacent cycles. The bench scenarios cover what needs a whole frame or a long window to show: the bit mapping of written words, readback and status contents, the measured strobe periods for every rate and source combination (including a zero divisor), the aborted frames and the flag-pin selection.

// File: rtl/arx_cfg_pkg.sv
`timescale 1ns/1ps
package arx_cfg_pkg;
  localparam int CMD_W  = 8;
  localparam int STAT_W = 8;

  localparam logic [CMD_W-1:0] CMD_CFG_WR  = 8'h10;
  localparam logic [CMD_W-1:0] CMD_CFG_RD  = 8'h0B;
  localparam logic [CMD_W-1:0] CMD_STAT_RD = 8'h0A;
  localparam logic [CMD_W-1:0] CMD_DIV_WR  = 8'h07;

  // configuration bit positions consumed by the receiver
  localparam int B_RATE   = 0;
  localparam int B_SRC    = 1;
  localparam int B_LABEL  = 2;
  localparam int B_PAR    = 3;
  localparam int B_DEC    = 4;
  localparam int B_RXEN   = 5;
  localparam int B_MATCH9 = 7;
  localparam int B_MATCH10= 8;
  localparam int B_REV    = 11;
  localparam int B_FLAG   = 15;

  typedef struct packed {
    logic       rate_low;
    logic       clk_src_div;
    logic       label_match_en;
    logic       parity_en;
    logic       decoder_en;
    logic       rx_enable;
    logic [1:0] decoder_match;
    logic       label_bit_rev;
    logic       flag_on_full;
  } rx_ctrl_t;
endpackage

// File: rtl/arx_spi_sync.sv
`timescale 1ns/1ps
module arx_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_idle,
  output logic mosi_s
);
  logic [STAGES-1:0] sck_p, cs_p, mosi_p;
  logic              sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      cs_p   <= '1;
      mosi_p <= '0;
      sck_d  <= 1'b0;
    end else begin
      sck_p[0]  <= sck;
      cs_p[0]   <= cs_n;
      mosi_p[0] <= mosi;
      sck_d     <= sck_p[STAGES-1];
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sck_p[g]  <= 1'b0;
        cs_p[g]   <= 1'b1;
        mosi_p[g] <= 1'b0;
      end else begin
        sck_p[g]  <= sck_p[g-1];
        cs_p[g]   <= cs_p[g-1];
        mosi_p[g] <= mosi_p[g-1];
      end
    end
  end

  assign sck_rise = sck_p[STAGES-1] & ~sck_d;
  assign sck_fall = ~sck_p[STAGES-1] & sck_d;
  assign cs_idle  = cs_p[STAGES-1];
  assign mosi_s   = mosi_p[STAGES-1];
endmodule

// File: rtl/arx_cmd_engine.sv
`timescale 1ns/1ps
module arx_cmd_engine
  import arx_cfg_pkg::*;
#(
  parameter int CFG_W = 16,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_idle,
  input  logic              mosi_s,
  input  logic [STAT_W-1:0] status_byte,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              miso
);
  localparam int CNT_W = $clog2(CMD_W + CFG_W + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] CFG_LAST = CNT_W'(CMD_W + CFG_W - 1);
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(CMD_W + DIV_W - 1);

  logic [CFG_W-2:0] rx_sh;
  logic [CFG_W-1:0] word_in;
  logic [CFG_W-1:0] tx_sh;
  logic [CNT_W-1:0] bit_cnt;
  logic [CMD_W-1:0] cmd_q;
  logic             cmd_seen, cmd_known, miso_q;
  logic             cfg_wr, div_wr, known_c;
  logic [CFG_W-1:0] resp_c;

  assign word_in = {rx_sh, mosi_s};

  always_comb begin
    known_c = 1'b1;
    resp_c  = '0;
    case (word_in[CMD_W-1:0])
      CMD_CFG_RD:  resp_c = cfg_q;
      CMD_STAT_RD: resp_c = {status_byte, {(CFG_W-STAT_W){1'b0}}};
      CMD_CFG_WR, CMD_DIV_WR: resp_c = '0;
      default:     known_c = 1'b0;
    endcase
  end

  assign cfg_wr = sck_rise && !cs_idle && cmd_seen && cmd_q == CMD_CFG_WR && bit_cnt == CFG_LAST;
  assign div_wr = sck_rise && !cs_idle && cmd_seen && cmd_q == CMD_DIV_WR && bit_cnt == DIV_LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh     <= '0;
      tx_sh     <= '0;
      bit_cnt   <= '0;
      cmd_q     <= '0;
      cmd_seen  <= 1'b0;
      cmd_known <= 1'b0;
      miso_q    <= 1'b0;
    end else if (cs_idle) begin
      tx_sh     <= '0;
      bit_cnt   <= '0;
      cmd_q     <= '0;
      cmd_seen  <= 1'b0;
      cmd_known <= 1'b0;
      miso_q    <= 1'b0;
    end else if (sck_rise) begin
      rx_sh <= word_in[CFG_W-2:0];
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == CMD_LAST) begin
        cmd_q     <= word_in[CMD_W-1:0];
        cmd_seen  <= 1'b1;
        cmd_known <= known_c;
        tx_sh     <= resp_c;
      end
    end else if (sck_fall) begin
      miso_q <= tx_sh[CFG_W-1];
      tx_sh  <= {tx_sh[CFG_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= word_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_wr) div_q <= word_in[DIV_W-1:0];
  end

  assign miso = miso_q;

  a_r2_cfg_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_q));
  a_r9_idle_clears_frame: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> (bit_cnt == '0 && !cmd_seen));
  a_r11_miso_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |=> !miso_q);
  a_r8_unknown_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_seen && !cmd_known) |-> !miso_q);
endmodule

// File: rtl/arx_rate_tick.sv
`timescale 1ns/1ps
module arx_rate_tick #(
  parameter int DIV_W    = 8,
  parameter int HI_RATIO = 10,
  parameter int LO_RATIO = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_low,
  input  logic             sel_div,
  input  logic [DIV_W-1:0] divisor,
  output logic             bit_tick
);
  localparam int PW = $clog2(LO_RATIO);
  localparam logic [PW-1:0] HI_LIM = PW'(HI_RATIO - 1);
  localparam logic [PW-1:0] LO_LIM = PW'(LO_RATIO - 1);

  logic [DIV_W-1:0] pre_cnt, div_eff;
  logic [PW-1:0]    post_cnt, lim;
  logic             src_en;

  assign div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
  assign src_en  = !sel_div || (pre_cnt >= div_eff - 1'b1);
  assign lim     = sel_low ? LO_LIM : HI_LIM;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      post_cnt <= '0;
      bit_tick <= 1'b0;
    end else begin
      bit_tick <= 1'b0;
      pre_cnt  <= src_en ? '0 : pre_cnt + 1'b1;
      if (src_en) begin
        if (post_cnt >= lim) begin
          post_cnt <= '0;
          bit_tick <= 1'b1;
        end else begin
          post_cnt <= post_cnt + 1'b1;
        end
      end
    end
  end

  a_r6_tick_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);
  a_r7_divided_enable_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_div && src_en && divisor > 1 && $stable(divisor)) |=> (!src_en || !sel_div || $changed(divisor)));
endmodule

// File: rtl/arx_cfg_port.sv
`timescale 1ns/1ps
module arx_cfg_port
  import arx_cfg_pkg::*;
#(
  parameter int CFG_W       = 16,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HI_RATIO    = 10,
  parameter int LO_RATIO    = 80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  input  logic       fifo_empty,
  input  logic       fifo_half,
  input  logic       fifo_full,
  output logic       rate_low,
  output logic       clk_src_div,
  output logic       label_match_en,
  output logic       parity_en,
  output logic       decoder_en,
  output logic       rx_enable,
  output logic [1:0] decoder_match,
  output logic       label_bit_rev,
  output logic       flag_on_full,
  output logic       rx_flag,
  output logic       bit_tick
);
  logic              sck_rise, sck_fall, cs_idle, mosi_s;
  logic [CFG_W-1:0]  cfg_q;
  logic [DIV_W-1:0]  div_q;
  logic [STAT_W-1:0] status_byte;
  rx_ctrl_t          ctrl;

  assign status_byte = {{(STAT_W-3){1'b0}}, fifo_full, fifo_half, fifo_empty};

  arx_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_idle(cs_idle), .mosi_s(mosi_s)
  );

  arx_cmd_engine #(.CFG_W(CFG_W), .DIV_W(DIV_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_idle(cs_idle), .mosi_s(mosi_s), .status_byte(status_byte),
    .cfg_q(cfg_q), .div_q(div_q), .miso(spi_miso)
  );

  always_comb begin
    ctrl.rate_low       = cfg_q[B_RATE];
    ctrl.clk_src_div    = cfg_q[B_SRC];
    ctrl.label_match_en = cfg_q[B_LABEL];
    ctrl.parity_en      = cfg_q[B_PAR];
    ctrl.decoder_en     = cfg_q[B_DEC];
    ctrl.rx_enable      = cfg_q[B_RXEN];
    ctrl.decoder_match  = {cfg_q[B_MATCH10], cfg_q[B_MATCH9]};
    ctrl.label_bit_rev  = cfg_q[B_REV];
    ctrl.flag_on_full   = cfg_q[B_FLAG];
  end

  assign rate_low       = ctrl.rate_low;
  assign clk_src_div    = ctrl.clk_src_div;
  assign label_match_en = ctrl.label_match_en;
  assign parity_en      = ctrl.parity_en;
  assign decoder_en     = ctrl.decoder_en;
  assign rx_enable      = ctrl.rx_enable;
  assign decoder_match  = ctrl.decoder_match;
  assign label_bit_rev  = ctrl.label_bit_rev;
  assign flag_on_full   = ctrl.flag_on_full;
  assign rx_flag        = ctrl.flag_on_full ? fifo_full : fifo_empty;

  arx_rate_tick #(.DIV_W(DIV_W), .HI_RATIO(HI_RATIO), .LO_RATIO(LO_RATIO)) u_tick (
    .clk(clk), .rst_n(rst_n), .sel_low(ctrl.rate_low), .sel_div(ctrl.clk_src_div),
    .divisor(div_q), .bit_tick(bit_tick)
  );
endmodule

// File: tb/sim_arx_cfg_port.sv
`timescale 1ns/1ps
module sim_arx_cfg_port;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic f_empty = 1'b1, f_half = 1'b0, f_full = 1'b0;
  logic rate_low, clk_src_div, label_match_en, parity_en, decoder_en, rx_enable;
  logic [1:0] decoder_match;
  logic label_bit_rev, flag_on_full, rx_flag, bit_tick;

  int checks = 0, errors = 0;
  logic [23:0] exp_q[$];
  logic [23:0] obs_q[$];
  string       tag_q[$];
  event        obs_ev;
  logic [15:0] cur_cfg = 16'h0;
  logic [7:0]  cur_div = 8'h0;

  always #4 clk = ~clk;

  arx_cfg_port u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .fifo_empty(f_empty), .fifo_half(f_half), .fifo_full(f_full),
    .rate_low(rate_low), .clk_src_div(clk_src_div), .label_match_en(label_match_en),
    .parity_en(parity_en), .decoder_en(decoder_en), .rx_enable(rx_enable),
    .decoder_match(decoder_match), .label_bit_rev(label_bit_rev),
    .flag_on_full(flag_on_full), .rx_flag(rx_flag), .bit_tick(bit_tick)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin : monitor
    forever begin
      @(obs_ev);
      while (obs_q.size() > 0 && exp_q.size() > 0)
        chk(tag_q.pop_front(), {8'h0, obs_q.pop_front()}, {8'h0, exp_q.pop_front()});
    end
  end

  task automatic frame(input int n, input logic [31:0] d, output logic [31:0] r);
    r = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = d[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      r = {r[30:0], miso};
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [15:0] v);
    logic [31:0] r;
    frame(24, {8'h0, 8'h10, v}, r);
    cur_cfg = v;
  endtask

  task automatic wr_div(input logic [7:0] v);
    logic [31:0] r;
    frame(16, {16'h0, 8'h07, v}, r);
    cur_div = v;
  endtask

  task automatic rd_cfg(input string tag);
    logic [31:0] r;
    exp_q.push_back({8'h00, cur_cfg});
    tag_q.push_back(tag);
    frame(24, {8'h0, 8'h0B, 16'h0}, r);
    obs_q.push_back(r[23:0]);
    ->obs_ev;
  endtask

  task automatic rd_stat(input string tag);
    logic [31:0] r;
    exp_q.push_back({16'h0, 5'b0, f_full, f_half, f_empty});
    tag_q.push_back(tag);
    frame(16, {16'h0, 8'h0A, 8'h0}, r);
    obs_q.push_back(r[23:0]);
    ->obs_ev;
  endtask

  task automatic chk_fields(input string tag);
    chk({tag, " R2 rate_low"},       rate_low,       cur_cfg[0]);
    chk({tag, " R2 clk_src_div"},    clk_src_div,    cur_cfg[1]);
    chk({tag, " R2 label_match_en"}, label_match_en, cur_cfg[2]);
    chk({tag, " R2 parity_en"},      parity_en,      cur_cfg[3]);
    chk({tag, " R2 decoder_en"},     decoder_en,     cur_cfg[4]);
    chk({tag, " R2 rx_enable"},      rx_enable,      cur_cfg[5]);
    chk({tag, " R2 decoder_match"},  decoder_match,  {cur_cfg[8], cur_cfg[7]});
    chk({tag, " R2 label_bit_rev"},  label_bit_rev,  cur_cfg[11]);
    chk({tag, " R2 flag_on_full"},   flag_on_full,   cur_cfg[15]);
  endtask

  task automatic chk_period(input string tag);
    int p, d, e;
    d = (cur_div == 8'h0) ? 1 : int'(cur_div);
    e = (cur_cfg[0] ? 80 : 10) * (cur_cfg[1] ? d : 1);
    for (int k = 0; k < 2; k++) begin
      do @(negedge clk); while (!bit_tick);
    end
    p = 0;
    do begin @(negedge clk); p++; end while (!bit_tick);
    chk(tag, p, e);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk_fields("R1 reset");
    chk("R11 miso idle after reset", miso, 1'b0);
    chk_period("R1 R6 reset tick period");
    rd_cfg("R1 R3 reset readback");

    wr_cfg(16'hA5C3);
    chk_fields("R2 word A5C3");
    rd_cfg("R3 readback A5C3");
    chk_period("R6 R7 slow rate divided source zero divisor");
    f_full = 1'b1; f_empty = 1'b0; #1;
    chk("R10 flag shows full", rx_flag, 1'b1);
    f_full = 1'b0; #1;
    chk("R10 flag full cleared", rx_flag, 1'b0);

    wr_cfg(16'h5A3C);
    chk_fields("R2 word 5A3C");
    rd_cfg("R3 readback 5A3C");
    chk_period("R6 fast rate raw source");
    f_empty = 1'b1; #1;
    chk("R10 flag shows empty", rx_flag, 1'b1);
    f_empty = 1'b0; f_full = 1'b1; #1;
    chk("R10 flag ignores full", rx_flag, 1'b0);

    f_empty = 1'b1; f_half = 1'b0; f_full = 1'b0;
    rd_stat("R4 status empty");
    f_empty = 1'b0; f_half = 1'b1; f_full = 1'b1;
    rd_stat("R4 status half and full");
    f_empty = 1'b0; f_half = 1'b1; f_full = 1'b0;
    rd_stat("R4 status half");

    wr_div(8'd3);
    wr_cfg(16'h0002);
    chk_period("R5 R7 divide by 3 fast");
    wr_cfg(16'h0003);
    chk_period("R5 R7 divide by 3 slow");
    wr_cfg(16'h0001);
    chk_period("R7 raw source slow");

    frame(12, {20'h0, 8'h07, 4'hF}, r);
    wr_cfg(16'h0002);
    chk_period("R9 aborted divisor write keeps divisor");
    frame(12, {20'h0, 8'h10, 4'hF}, r);
    chk_fields("R9 aborted config write");
    rd_cfg("R9 readback after abort");

    frame(24, {8'h0, 8'h55, 16'hFFFF}, r);
    chk("R8 unknown command miso", r[23:0], 24'h0);
    chk_fields("R8 unknown command no change");
    rd_cfg("R8 readback after unknown");
    frame(24, {8'h0, 8'hFF, 16'hFFFF}, r);
    chk("R8 command FF miso", r[23:0], 24'h0);
    rd_cfg("R8 readback after FF");
    chk("R11 miso idle between frames", miso, 1'b0);

    repeat (4) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule